// File: doc/BRIEF.md
# Single-precision round-and-pack stage with run-time rounding mode

This block takes the exact result of a floating-point operation and turns it into a packed single-precision word with its five exception flags. The arithmetic core in front of it supplies a sign, an unbiased exponent and a normalized significand. The significand is wider than the stored precision, and its lowest bits act as guard, round and sticky bits. The core also raises indicators for a NaN, an infinite or a zero result, for a signaling-NaN operand, and for invalid and divide-by-zero conditions. The stage is purely combinational.

The rounding mode is chosen on every operation by a 5-bit one-hot select. If more than one bit is set, the lowest-numbered set bit decides. If no bit is set, the output is a quiet NaN. Values too small for the normal range are denormalized, and the bits shifted out are folded into sticky. Values too large for the format saturate to either infinity or the largest finite value. Which one depends on the mode and the sign.

Top module: `fp_round_pack`

## Requirements
- R1: The result word has the sign in bit 31, the exponent biased by 127 in bits 30:23 and the fraction in bits 22:0. The input significand `sig_i` is 27 bits wide: bit 26 is the hidden bit, bits 25:3 are the fraction and bits 2:0 are guard, round and sticky. Its value is sig_i / 2^26 * 2^exp_i. A normal value with zero guard, round and sticky bits packs exactly with every flag clear. Flags are listed here as {nv,dz,of,uf,nx}.
- R2: The rounding mode `rm_i` is one-hot. Bit 0 selects nearest with ties to even, bit 1 nearest with ties away from zero, bit 2 toward +infinity, bit 3 toward -infinity and bit 4 toward zero. When several bits are set, the lowest set bit is the one used.
- R3: With `rm_i` equal to zero the result is 0x7FC00000, whatever the other inputs are. In that case `nv_o` equals `snan_i` and the other four flags are 0.
- R4: The discarded bits round the 24-bit significand. Ties-to-even adds one on an exact half only when the kept LSB is 1, and above half always. Ties-away adds one on any half or more. Toward +infinity adds one on any nonzero remainder of a positive value, toward -infinity on any nonzero remainder of a negative value, and toward zero never. `nx_o` is 1 whenever the discarded part is nonzero.
- R5: A carry out of the significand increment gives a significand of 1.0 and raises the exponent by one.
- R6: Overflow occurs when the final biased exponent reaches 255. It sets `of_o` and `nx_o` and returns a value that depends on the mode and the sign:
  - both nearest modes return infinity of the result's sign;
  - toward +infinity returns +infinity (0x7F800000) for a positive result and 0xFF7FFFFF for a negative one;
  - toward -infinity returns 0x7F7FFFFF for a positive result and -infinity (0xFF800000) for a negative one;
  - toward zero returns 0x7F7FFFFF or 0xFF7FFFFF by sign.
- R7: When the biased exponent is below 1, the significand is shifted right by (1 - biased exponent) before rounding, with every shifted-out bit ORed into sticky. The result then has exponent field 0, unless rounding reaches the hidden bit, which gives exponent field 1.
- R8: `uf_o` is 1 exactly when the result took the denormalizing path, was inexact and is delivered as subnormal or zero. `uf_o` therefore always comes with `nx_o` and with exponent field 0.
- R9: With a valid mode, the special indicators override everything else:
  - `nan_i` gives 0x7FC00000 and has priority over the others;
  - `inf_i` gives infinity of `sign_i`;
  - `zero_i` gives zero of `sign_i`.
  In all three cases `of_o`, `uf_o` and `nx_o` are 0.
- R10: With a valid mode, `nv_o` is `inv_i` OR `snan_i` and `dz_o` equals `dz_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the exact result |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| sig_i | input | 27 | Normalized significand: hidden bit, fraction, guard, round, sticky |
| rm_i | input | 5 | One-hot rounding-mode select |
| nan_i | input | 1 | Core result is NaN |
| snan_i | input | 1 | An operand was a signaling NaN |
| inf_i | input | 1 | Core result is infinite |
| zero_i | input | 1 | Core result is exactly zero |
| inv_i | input | 1 | Core reports an invalid operation |
| dz_i | input | 1 | Core reports division by zero |
| res_o | output | 32 | Packed single-precision result |
| nv_o | output | 1 | Invalid-operation flag |
| dz_o | output | 1 | Divide-by-zero flag |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |

## Verification
The bench applies exact ties to both kinds of significand, one with an even LSB and one with an odd LSB, in every mode and with both signs. A rounder that mixes up ties-to-even and ties-away, or a directed mode that ignores the sign, is off by one ULP on these. Overflow is driven in all five modes with both signs, so that a wrong saturation rule shows up as infinity where the largest finite value belongs, or the reverse. Near the bottom of the range the bench checks several cases:
- the exact minimum subnormal;
- a half-ULP tie below it;
- a shift larger than the whole significand, where a design that drops sticky would return zero;
- a value that rounds up into the smallest normal, where the underflow flag must stay clear.

Mode vectors with several bits set, and the all-zero mode, expose a design that chooses the wrong winner or that fails to produce the NaN fallback.

// File: rtl/fp_rnd_pkg.sv
package fp_rnd_pkg;

   localparam int NUM_MODES = 5;
   localparam int MI_EVEN   = 0;
   localparam int MI_AWAY   = 1;
   localparam int MI_UP     = 2;
   localparam int MI_DOWN   = 3;
   localparam int MI_ZERO   = 4;

   typedef struct packed {
      logic nv;
      logic dz;
      logic of;
      logic uf;
      logic nx;
   } fp_flags_t;

endpackage

// File: rtl/fp_rnd_mode_dec.sv
module fp_rnd_mode_dec #(
   parameter int N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         none_o
);

   logic [N:0] seen;

   always_comb begin
      seen[0] = 1'b0;
      for (int i = 0; i < N; i++) begin
         gnt_o[i]   = req_i[i] & ~seen[i];
         seen[i+1]  = seen[i] | req_i[i];
      end
      none_o = ~seen[N];
   end

endmodule

// File: rtl/fp_rnd_rshift_sticky.sv
module fp_rnd_rshift_sticky #(
   parameter int W    = 27,
   parameter int SH_W = 11
) (
   input  logic [W-1:0]    x_i,
   input  logic [SH_W-1:0] sh_i,
   output logic [W-1:0]    y_o
);

   localparam logic [SH_W-1:0] SH_MAX = SH_W'(W);

   logic [SH_W-1:0] sh_c;
   logic [2*W-1:0]  wide;

   always_comb begin
      sh_c = (sh_i > SH_MAX) ? SH_MAX : sh_i;
      wide = {x_i, {W{1'b0}}} >> sh_c;
      y_o  = {wide[2*W-1:W+1], wide[W] | (|wide[W-1:0])};
   end

   // R7: nonzero input never vanishes through the shift
   always_comb begin
      if (|x_i) a_r7_sticky_kept: assert (|y_o);
   end

endmodule

// File: rtl/fp_rnd_incr.sv
module fp_rnd_incr #(
   parameter int SIG_W = 24,
   parameter int GRS_W = 3
) (
   input  logic [SIG_W+GRS_W-1:0] v_i,
   input  logic                   sign_i,
   input  logic [4:0]             gnt_i,
   output logic [SIG_W:0]         m_o,
   output logic                   inexact_o
);
   import fp_rnd_pkg::*;

   logic lsb, guard, sticky, inc;

   assign lsb   = v_i[GRS_W];
   assign guard = v_i[GRS_W-1];

   generate
      if (GRS_W > 2) begin : g_wide_tail
         assign sticky = |v_i[GRS_W-2:0];
      end else begin : g_narrow_tail
         assign sticky = v_i[0];
      end
   endgenerate

   always_comb begin
      inc = 1'b0;
      if (gnt_i[MI_EVEN]) inc = guard & (sticky | lsb);
      if (gnt_i[MI_AWAY]) inc = guard;
      if (gnt_i[MI_UP])   inc = ~sign_i & (guard | sticky);
      if (gnt_i[MI_DOWN]) inc = sign_i & (guard | sticky);
      if (gnt_i[MI_ZERO]) inc = 1'b0;
      m_o       = {1'b0, v_i[SIG_W+GRS_W-1:GRS_W]} + (SIG_W+1)'(inc);
      inexact_o = guard | sticky;
   end

   // R4: truncation mode leaves the kept significand untouched
   always_comb begin
      if (gnt_i[MI_ZERO])
         a_r4_trunc_no_inc: assert (m_o == {1'b0, v_i[SIG_W+GRS_W-1:GRS_W]});
   end

endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
   parameter int EXP_W = 8,
   parameter int SIG_W = 24,
   parameter int GRS_W = 3
) (
   input  logic                       sign_i,
   input  logic signed [EXP_W+1:0]    exp_i,
   input  logic [SIG_W+GRS_W-1:0]     sig_i,
   input  logic [4:0]                 rm_i,
   input  logic                       nan_i,
   input  logic                       snan_i,
   input  logic                       inf_i,
   input  logic                       zero_i,
   input  logic                       inv_i,
   input  logic                       dz_i,
   output logic [EXP_W+SIG_W-1:0]     res_o,
   output logic                       nv_o,
   output logic                       dz_o,
   output logic                       of_o,
   output logic                       uf_o,
   output logic                       nx_o
);
   import fp_rnd_pkg::*;

   localparam int EW   = EXP_W + 2;
   localparam int VW   = SIG_W + GRS_W;
   localparam int RW   = EXP_W + SIG_W;
   localparam int FW   = SIG_W - 1;
   localparam logic signed [EW:0] BIAS_S = (EW+1)'(2**(EXP_W-1) - 1);
   localparam logic signed [EW:0] ONE_S  = (EW+1)'(1);
   localparam logic signed [EW:0] EMAX_S = (EW+1)'(2**EXP_W - 1);
   localparam logic [EXP_W-1:0]   E_ONES = {EXP_W{1'b1}};
   localparam logic [RW-1:0]      QNAN   = {1'b0, E_ONES, 1'b1, {(FW-1){1'b0}}};

   generate
      if (EXP_W < 3 || SIG_W < 3) begin : g_bad_fmt
         $error("fp_round_pack: exponent and significand widths must be at least 3");
      end
      if (GRS_W < 2) begin : g_bad_tail
         $error("fp_round_pack: at least a guard and a sticky bit are required");
      end
   endgenerate

   // mode selection
   logic [NUM_MODES-1:0] gnt;
   logic                 no_mode;

   fp_rnd_mode_dec #(.N(NUM_MODES)) u_mode (
      .req_i  (rm_i),
      .gnt_o  (gnt),
      .none_o (no_mode)
   );

   // exponent biasing and denormalization
   logic signed [EW:0] ebias;
   logic signed [EW:0] e_fin;
   logic               sub_path;
   logic [EW:0]        sh_amt;
   logic [VW-1:0]      shifted;
   logic [VW-1:0]      rvec;

   always_comb begin
      ebias    = $signed({exp_i[EW-1], exp_i}) + BIAS_S;
      sub_path = (ebias < ONE_S);
      sh_amt   = sub_path ? $unsigned(ONE_S - ebias) : '0;
   end

   fp_rnd_rshift_sticky #(.W(VW), .SH_W(EW+1)) u_shift (
      .x_i  (sig_i),
      .sh_i (sh_amt),
      .y_o  (shifted)
   );

   assign rvec = sub_path ? shifted : sig_i;

   // rounding
   logic [SIG_W:0] m_r;
   logic           inexact;

   fp_rnd_incr #(.SIG_W(SIG_W), .GRS_W(GRS_W)) u_round (
      .v_i       (rvec),
      .sign_i    (sign_i),
      .gnt_i     (gnt),
      .m_o       (m_r),
      .inexact_o (inexact)
   );

   // packing
   logic [RW-1:0]    inf_word, max_word, fin_word, ovf_word;
   logic [EXP_W-1:0] e_field;
   logic             ovf, to_inf;
   fp_flags_t        fl;

   always_comb begin
      e_fin    = ebias + $signed({{EW{1'b0}}, m_r[SIG_W]});
      ovf      = ~sub_path & (e_fin >= EMAX_S);
      e_field  = sub_path ? {{(EXP_W-1){1'b0}}, m_r[SIG_W-1]} : e_fin[EXP_W-1:0];
      fin_word = {sign_i, e_field, m_r[FW-1:0]};
      inf_word = {sign_i, E_ONES, {FW{1'b0}}};
      max_word = {sign_i, E_ONES - 1'b1, {FW{1'b1}}};
      to_inf   = gnt[MI_EVEN] | gnt[MI_AWAY] |
                 (gnt[MI_UP] & ~sign_i) | (gnt[MI_DOWN] & sign_i);
      ovf_word = to_inf ? inf_word : max_word;
   end

   always_comb begin
      fl    = '0;
      res_o = QNAN;
      if (no_mode) begin
         fl.nv = snan_i;
      end else begin
         fl.nv = inv_i | snan_i;
         fl.dz = dz_i;
         if (nan_i) begin
            res_o = QNAN;
         end else if (inf_i) begin
            res_o = inf_word;
         end else if (zero_i || !sig_i[VW-1]) begin
            res_o = {sign_i, {(RW-1){1'b0}}};
         end else if (ovf) begin
            res_o = ovf_word;
            fl.of = 1'b1;
            fl.nx = 1'b1;
         end else begin
            res_o = fin_word;
            fl.nx = inexact;
            fl.uf = sub_path & inexact & ~m_r[SIG_W-1];
         end
      end
      {nv_o, dz_o, of_o, uf_o, nx_o} = fl;
   end

   // R2: at most one rounding rule is ever in force
   always_comb begin
      a_r2_single_mode: assert ($onehot0(gnt));
   end

   // R3: an empty mode select always delivers the quiet NaN
   always_comb begin
      if (rm_i == '0) a_r3_no_mode_nan: assert (res_o == QNAN && !of_o && !uf_o && !nx_o);
   end

   // R6: upward rounding never overflows to negative infinity
   always_comb begin
      if (of_o && rm_i[0] == 1'b0 && rm_i[1] == 1'b0 && rm_i[2])
         a_r6_up_no_neg_inf: assert (res_o != {1'b1, E_ONES, {FW{1'b0}}});
   end

   // R6: truncation never overflows to an infinity
   always_comb begin
      if (of_o && rm_i == 5'b10000)
         a_r6_trunc_finite: assert (res_o[RW-2:FW] != E_ONES);
   end

   // R8: underflow only with inexact and a subnormal or zero result
   always_comb begin
      if (uf_o) a_r8_uf_tiny_inexact: assert (nx_o && res_o[RW-2:FW] == '0);
   end

endmodule

// File: tb/fp_round_pack_tb_top.sv
module fp_round_pack_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] M_EVEN = 5'b00001;
   localparam logic [4:0] M_AWAY = 5'b00010;
   localparam logic [4:0] M_UP   = 5'b00100;
   localparam logic [4:0] M_DOWN = 5'b01000;
   localparam logic [4:0] M_ZERO = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              sign_i;
   logic signed [9:0] exp_i;
   logic [26:0]       sig_i;
   logic [4:0]        rm_i;
   logic nan_i, snan_i, inf_i, zero_i, inv_i, dz_i;
   logic [31:0]       res_o;
   logic nv_o, dz_o, of_o, uf_o, nx_o;

   int checks = 0;
   int fails  = 0;

   fp_round_pack dut_i (
      .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i), .rm_i(rm_i),
      .nan_i(nan_i), .snan_i(snan_i), .inf_i(inf_i), .zero_i(zero_i),
      .inv_i(inv_i), .dz_i(dz_i), .res_o(res_o), .nv_o(nv_o), .dz_o(dz_o),
      .of_o(of_o), .uf_o(uf_o), .nx_o(nx_o)
   );

   task automatic clear();
      sign_i = 1'b0; exp_i = '0; sig_i = '0; rm_i = M_EVEN;
      nan_i = 1'b0; snan_i = 1'b0; inf_i = 1'b0; zero_i = 1'b0;
      inv_i = 1'b0; dz_i = 1'b0;
   endtask

   // flags as {nv,dz,of,uf,nx}
   task automatic expect_out(input logic [31:0] er, input logic [4:0] ef, input string tag);
      @(negedge clk);
      #(CLK_PERIOD/4);
      checks++;
      if (res_o !== er || {nv_o, dz_o, of_o, uf_o, nx_o} !== ef) begin
         fails++;
         $display("FAIL %s: res=%08h flags=%05b expected res=%08h flags=%05b",
                  tag, res_o, {nv_o, dz_o, of_o, uf_o, nx_o}, er, ef);
      end
   endtask

   task automatic fin(input logic s, input int e, input logic [26:0] sg, input logic [4:0] rm,
                      input logic [31:0] er, input logic [4:0] ef, input string tag);
      @(negedge clk);
      clear();
      sign_i = s; exp_i = 10'(e); sig_i = sg; rm_i = rm;
      expect_out(er, ef, tag);
   endtask

   task automatic t_reset();
      @(negedge clk);
      clear();
      zero_i = 1'b1;
      expect_out(32'h00000000, 5'b00000, "R9 zero after reset");
   endtask

   task automatic t_exact();
      fin(0, 0, 27'h4000000, M_EVEN, 32'h3F800000, 5'b00000, "R1 one");
      fin(0, 1, 27'h6000000, M_UP,   32'h40400000, 5'b00000, "R1 three");
      fin(0, 127, 27'h7FFFFF8, M_EVEN, 32'h7F7FFFFF, 5'b00000, "R1 max finite");
   endtask

   task automatic t_nearest();
      fin(0, 0, 27'h4000004, M_EVEN, 32'h3F800000, 5'b00001, "R4 even tie lsb0");
      fin(0, 0, 27'h4000004, M_AWAY, 32'h3F800001, 5'b00001, "R4 away tie lsb0");
      fin(1, 0, 27'h400000C, M_EVEN, 32'hBF800002, 5'b00001, "R4 even tie lsb1");
      fin(1, 0, 27'h400000C, M_AWAY, 32'hBF800002, 5'b00001, "R4 away tie neg");
      fin(0, 0, 27'h4000003, M_EVEN, 32'h3F800000, 5'b00001, "R4 even below half");
      fin(0, 0, 27'h4000003, M_AWAY, 32'h3F800000, 5'b00001, "R4 away below half");
      fin(0, 0, 27'h4000005, M_EVEN, 32'h3F800001, 5'b00001, "R4 even above half");
   endtask

   task automatic t_directed();
      fin(0, 0, 27'h4000004, M_UP,   32'h3F800001, 5'b00001, "R4 up pos");
      fin(0, 0, 27'h4000004, M_DOWN, 32'h3F800000, 5'b00001, "R4 down pos");
      fin(0, 0, 27'h4000004, M_ZERO, 32'h3F800000, 5'b00001, "R4 zero pos");
      fin(1, 0, 27'h400000C, M_UP,   32'hBF800001, 5'b00001, "R4 up neg");
      fin(1, 0, 27'h400000C, M_DOWN, 32'hBF800002, 5'b00001, "R4 down neg");
      fin(1, 0, 27'h400000C, M_ZERO, 32'hBF800001, 5'b00001, "R4 zero neg");
      fin(0, 0, 27'h4000003, M_UP,   32'h3F800001, 5'b00001, "R4 up sticky only");
   endtask

   task automatic t_priority();
      fin(0, 0, 27'h4000004, 5'b11110, 32'h3F800001, 5'b00001, "R2 bit1 wins");
      fin(0, 0, 27'h4000004, 5'b11111, 32'h3F800000, 5'b00001, "R2 bit0 wins");
      fin(0, 0, 27'h4000004, 5'b10100, 32'h3F800001, 5'b00001, "R2 bit2 over bit4");
      fin(1, 0, 27'h400000C, 5'b11000, 32'hBF800002, 5'b00001, "R2 bit3 over bit4");
   endtask

   task automatic t_nomode();
      @(negedge clk);
      clear();
      rm_i = 5'b00000; sig_i = 27'h4000004; inv_i = 1'b1; dz_i = 1'b1;
      expect_out(32'h7FC00000, 5'b00000, "R3 no mode");
      @(negedge clk);
      clear();
      rm_i = 5'b00000; snan_i = 1'b1; inf_i = 1'b1;
      expect_out(32'h7FC00000, 5'b10000, "R3 no mode snan");
   endtask

   task automatic t_carry();
      fin(0, 0, 27'h7FFFFFC, M_EVEN, 32'h40000000, 5'b00001, "R5 carry renorm");
      fin(1, 3, 27'h7FFFFF9, M_DOWN, 32'hC1800000, 5'b00001, "R5 carry neg");
      fin(0, 127, 27'h7FFFFFC, M_EVEN, 32'h7F800000, 5'b00101, "R5 carry into overflow");
   endtask

   task automatic t_overflow();
      fin(0, 128, 27'h4000000, M_EVEN, 32'h7F800000, 5'b00101, "R6 even pos");
      fin(1, 128, 27'h4000000, M_AWAY, 32'hFF800000, 5'b00101, "R6 away neg");
      fin(0, 128, 27'h4000000, M_UP,   32'h7F800000, 5'b00101, "R6 up pos");
      fin(1, 128, 27'h4000000, M_UP,   32'hFF7FFFFF, 5'b00101, "R6 up neg");
      fin(0, 128, 27'h4000000, M_DOWN, 32'h7F7FFFFF, 5'b00101, "R6 down pos");
      fin(1, 128, 27'h4000000, M_DOWN, 32'hFF800000, 5'b00101, "R6 down neg");
      fin(0, 128, 27'h4000000, M_ZERO, 32'h7F7FFFFF, 5'b00101, "R6 zero pos");
      fin(1, 200, 27'h4000000, M_ZERO, 32'hFF7FFFFF, 5'b00101, "R6 zero neg");
      fin(0, 127, 27'h7FFFFFF, M_ZERO, 32'h7F7FFFFF, 5'b00001, "R6 trunc no overflow");
   endtask

   task automatic t_subnormal();
      fin(0, -127, 27'h4000000, M_EVEN, 32'h00400000, 5'b00000, "R7 half min normal");
      fin(0, -149, 27'h4000000, M_EVEN, 32'h00000001, 5'b00000, "R7 min subnormal");
      fin(0, -127, 27'h7FFFFF8, M_EVEN, 32'h00800000, 5'b00001, "R7 rounds to min normal");
      fin(1, -160, 27'h4000000, M_DOWN, 32'h80000001, 5'b00011, "R7 full shift sticky");
      fin(0, -160, 27'h4000000, M_UP,   32'h00000001, 5'b00011, "R7 full shift up");
   endtask

   task automatic t_underflow();
      fin(0, -150, 27'h4000000, M_EVEN, 32'h00000000, 5'b00011, "R8 tie to zero");
      fin(0, -150, 27'h4000000, M_AWAY, 32'h00000001, 5'b00011, "R8 tie away");
      fin(0, -151, 27'h4000000, M_UP,   32'h00000001, 5'b00011, "R8 quarter up");
      fin(0, -151, 27'h4000000, M_EVEN, 32'h00000000, 5'b00011, "R8 quarter even");
      fin(1, -160, 27'h4000000, M_ZERO, 32'h80000000, 5'b00011, "R8 trunc to zero");
      fin(0, -127, 27'h7FFFFF8, M_ZERO, 32'h007FFFFF, 5'b00011, "R8 trunc below min normal");
   endtask

   task automatic t_special();
      @(negedge clk);
      clear();
      nan_i = 1'b1; inf_i = 1'b1; sig_i = 27'h4000004;
      expect_out(32'h7FC00000, 5'b00000, "R9 nan priority");
      @(negedge clk);
      clear();
      inf_i = 1'b1; sign_i = 1'b1; exp_i = 10'sd128; sig_i = 27'h4000000;
      expect_out(32'hFF800000, 5'b00000, "R9 neg inf");
      @(negedge clk);
      clear();
      zero_i = 1'b1; sign_i = 1'b1; sig_i = 27'h4000004; rm_i = M_UP;
      expect_out(32'h80000000, 5'b00000, "R9 neg zero");
   endtask

   task automatic t_invalid();
      @(negedge clk);
      clear();
      inv_i = 1'b1; sig_i = 27'h4000000;
      expect_out(32'h3F800000, 5'b10000, "R10 core invalid");
      @(negedge clk);
      clear();
      nan_i = 1'b1; snan_i = 1'b1;
      expect_out(32'h7FC00000, 5'b10000, "R10 signaling nan");
      @(negedge clk);
      clear();
      inf_i = 1'b1; dz_i = 1'b1;
      expect_out(32'h7F800000, 5'b01000, "R10 divide by zero");
   endtask

   initial begin
      clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_exact();
      t_nearest();
      t_directed();
      t_priority();
      t_nomode();
      t_carry();
      t_overflow();
      t_subnormal();
      t_underflow();
      t_special();
      t_invalid();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule